// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Reload

This block turns the two phase signals of an incremental shaft encoder, plus its once-per-revolution index pulse, into a bidirectional position count. Each pin first passes through a two-stage synchronizer and then a glitch filter whose length can be programmed. After that, every legal phase transition moves the count by one. A wrong phase sequence raises a sticky error flag and leaves the count alone.

The count runs from zero to a programmable ceiling and wraps at both ends. A swap control exchanges the roles of the two phase pins, which reverses the sense of counting. When index reload is enabled, a rising index edge puts the count at zero if the last step was forward, or at the ceiling if the last step was in reverse.

The block also reports the filtered pin levels and a flag that is set once the first index edge has been seen. An interval timer measures the clock cycles between accepted steps, and it raises an overflow flag when the running interval reaches the end of its range. Velocity arithmetic is done elsewhere, from the captured interval.

Top module: `qenc_decoder`

## Requirements
- R1: Each pin level must be held for 2 synchronizer cycles plus `filt_len_i`+1 consecutive samples, so that a held change appears on its level output exactly `filt_len_i`+3 clock edges after the pin changes. A pulse shorter than `filt_len_i`+1 cycles never reaches the level outputs or the count.
- R2: Forward rotation is the sequence {A,B} = 00→10→11→01→00, where A leads B. Each of these transitions adds one to `count_o`, one clock edge after the level outputs change.
- R3: Each transition of the reverse sequence {A,B} = 00→01→11→10→00 subtracts one from `count_o`.
- R4: A forward step at `max_cnt_i` gives 0. A reverse step at 0 gives `max_cnt_i`.
- R5: With `swap_i` = 1, the A pin drives the counter's B input and the B pin drives its A input, so an A pin that leads the B pin counts down. Changing `swap_i` alone moves no count.
- R6: A sample in which both filtered phases change at once sets `err_o`, leaves `count_o` unchanged, and `err_o` stays set until reset.
- R7: With `zero_rst_en_i` = 0, the index input does not change `count_o`.
- R8: With `zero_rst_en_i` = 1, a rising filtered index loads 0 if the last accepted step was forward (the direction after reset), or loads `max_cnt_i` if it was reverse. This load takes priority over a step in the same cycle.
- R9: `first_z_o` is set by the first rising filtered index, whatever the value of `zero_rst_en_i`, and stays set until reset.
- R10: On each accepted step, `evt_time_o` captures the number of clock cycles since the previous accepted step, saturating at 2^TMR_W−1.
- R11: `evt_ovf_o` is set once the running interval reaches 2^TMR_W−1 cycles without a step, and is cleared by the next accepted step.
- R12: After reset, `count_o`, `err_o`, `first_z_o`, `evt_ovf_o`, `evt_time_o` and the level outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Phase A pin |
| enc_b_i | input | 1 | Phase B pin |
| enc_z_i | input | 1 | Index pin |
| swap_i | input | 1 | Exchange the A and B roles |
| zero_rst_en_i | input | 1 | Let the index reload the count |
| max_cnt_i | input | CNT_W | Count ceiling |
| filt_len_i | input | FILT_W | Glitch filter length |
| count_o | output | CNT_W | Position count |
| dir_rev_o | output | 1 | Last accepted step was reverse |
| err_o | output | 1 | Sticky illegal-transition flag |
| a_lvl_o | output | 1 | Filtered A level |
| b_lvl_o | output | 1 | Filtered B level |
| z_lvl_o | output | 1 | Filtered index level |
| first_z_o | output | 1 | First index edge seen |
| evt_time_o | output | TMR_W | Cycles between the last two steps |
| evt_ovf_o | output | 1 | Running interval out of range |

## Verification
A stale previous-phase register or a wrong direction decode shows up on `count_o` one edge after the level outputs move. A swapped decode shows as a count that moves the wrong way. A filter counter that is off by one shifts the level outputs by a single cycle, so the bench samples on both sides of the expected edge. A wrong direction memory only becomes visible at the next index reload, so the bench reloads after both forward and reverse steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic {DIR_FWD = 1'b0, DIR_REV = 1'b1} dir_e;

  typedef struct packed {
    logic a;
    logic b;
  } phase_t;
endpackage

// File: rtl/qenc_sync_filt.sv
module qenc_sync_filt #(
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [FILT_W-1:0] len_i,
  output logic              lvl_o
);
  logic [1:0]        sync_q;
  logic [FILT_W-1:0] run_q;
  logic              lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      if (sync_q[1] == lvl_q) begin
        run_q <= '0;
      end else if (run_q == len_i) begin
        lvl_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/qenc_count.sv
module qenc_count
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             z_i,
  input  logic             swap_i,
  input  logic             zen_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_rev_o,
  output logic             err_o,
  output logic             first_z_o,
  output logic             step_o
);
  phase_t           prev_q;
  logic             pz_q;
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic             err_q, fz_q;

  phase_t cur_c, old_c;
  logic   chg_a, chg_b, step, illegal, fwd, z_rise;

  // swap applied to both samples so toggling swap_i alone is not an edge
  always_comb begin
    cur_c = swap_i ? '{a: b_i, b: a_i} : '{a: a_i, b: b_i};
    old_c = swap_i ? '{a: prev_q.b, b: prev_q.a} : prev_q;
  end

  assign chg_a   = cur_c.a ^ old_c.a;
  assign chg_b   = cur_c.b ^ old_c.b;
  assign step    = chg_a ^ chg_b;
  assign illegal = chg_a & chg_b;
  assign fwd     = cur_c.a ^ old_c.b;
  assign z_rise  = z_i & ~pz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pz_q   <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= DIR_FWD;
      err_q  <= 1'b0;
      fz_q   <= 1'b0;
    end else begin
      prev_q <= '{a: a_i, b: b_i};
      pz_q   <= z_i;
      if (z_rise) fz_q <= 1'b1;
      if (illegal) err_q <= 1'b1;
      if (step) dir_q <= fwd ? DIR_FWD : DIR_REV;
      if (z_rise && zen_i) begin
        cnt_q <= (dir_q == DIR_REV) ? max_i : '0;
      end else if (step) begin
        if (fwd) cnt_q <= (cnt_q == max_i) ? '0 : cnt_q + 1'b1;
        else     cnt_q <= (cnt_q == '0) ? max_i : cnt_q - 1'b1;
      end
    end
  end

  assign count_o   = cnt_q;
  assign dir_rev_o = (dir_q == DIR_REV);
  assign err_o     = err_q;
  assign first_z_o = fz_q;
  assign step_o    = step;
endmodule

// File: rtl/qenc_evt_timer.sv
module qenc_evt_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [TMR_W-1:0] time_o,
  output logic             ovf_o
);
  localparam logic [TMR_W-1:0] TopVal = '1;

  logic [TMR_W-1:0] run_q, cap_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      cap_q <= '0;
      ovf_q <= 1'b0;
    end else if (step_i) begin
      cap_q <= (run_q == TopVal) ? TopVal : run_q + 1'b1;
      run_q <= '0;
      ovf_q <= 1'b0;
    end else if (run_q == TopVal) begin
      ovf_q <= 1'b1;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign time_o = cap_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder #(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4,
  parameter int TMR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              enc_z_i,
  input  logic              swap_i,
  input  logic              zero_rst_en_i,
  input  logic [CNT_W-1:0]  max_cnt_i,
  input  logic [FILT_W-1:0] filt_len_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_rev_o,
  output logic              err_o,
  output logic              a_lvl_o,
  output logic              b_lvl_o,
  output logic              z_lvl_o,
  output logic              first_z_o,
  output logic [TMR_W-1:0]  evt_time_o,
  output logic              evt_ovf_o
);
  localparam int NumPins = 3;

  logic [NumPins-1:0] pins, lvls;
  logic               step;

  assign pins = {enc_z_i, enc_b_i, enc_a_i};

  for (genvar i = 0; i < NumPins; i++) begin : g_pin
    qenc_sync_filt #(.FILT_W(FILT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[i]),
      .len_i  (filt_len_i),
      .lvl_o  (lvls[i])
    );
  end

  assign a_lvl_o = lvls[0];
  assign b_lvl_o = lvls[1];
  assign z_lvl_o = lvls[2];

  qenc_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (lvls[0]),
    .b_i       (lvls[1]),
    .z_i       (lvls[2]),
    .swap_i    (swap_i),
    .zen_i     (zero_rst_en_i),
    .max_i     (max_cnt_i),
    .count_o   (count_o),
    .dir_rev_o (dir_rev_o),
    .err_o     (err_o),
    .first_z_o (first_z_o),
    .step_o    (step)
  );

  qenc_evt_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .time_o (evt_time_o),
    .ovf_o  (evt_ovf_o)
  );
endmodule

// File: rtl/qenc_decoder_chk.sv
module qenc_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             zero_rst_en_i,
  input logic [CNT_W-1:0] max_cnt_i,
  input logic [CNT_W-1:0] count_o,
  input logic             err_o,
  input logic             a_lvl_o,
  input logic             b_lvl_o,
  input logic             z_lvl_o,
  input logic             first_z_o
);
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R6
  dual_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(a_lvl_o) && !$stable(b_lvl_o)) |=> err_o);

  // R9
  first_z_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_z_o |=> first_z_o);

  // R2
  count_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(a_lvl_o) && $stable(b_lvl_o) && $stable(z_lvl_o)) |=> $stable(count_o));

  // R4
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o <= max_cnt_i && $stable(max_cnt_i)) |=> count_o <= max_cnt_i);

  // R7
  z_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(z_lvl_o) && !zero_rst_en_i && $stable(a_lvl_o) && $stable(b_lvl_o))
      |=> $stable(count_o));
endmodule

bind qenc_decoder qenc_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .zero_rst_en_i (zero_rst_en_i),
  .max_cnt_i     (max_cnt_i),
  .count_o       (count_o),
  .err_o         (err_o),
  .a_lvl_o       (a_lvl_o),
  .b_lvl_o       (b_lvl_o),
  .z_lvl_o       (z_lvl_o),
  .first_z_o     (first_z_o)
);

// File: tb/sim_qenc_decoder.sv
`timescale 1ns/1ps
module sim_qenc_decoder;
  localparam int CNT_W = 8;
  localparam int FILT_W = 4;
  localparam int TMR_W = 8;
  localparam int NVEC = 13;
  // {swap, pin a, pin b, expected count}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b010, 8'd1}, {3'b011, 8'd2}, {3'b001, 8'd3}, {3'b000, 8'd4},
    {3'b001, 8'd3}, {3'b011, 8'd2}, {3'b010, 8'd1}, {3'b000, 8'd0},
    {3'b001, 8'd9}, {3'b000, 8'd0}, {3'b100, 8'd0}, {3'b110, 8'd9},
    {3'b111, 8'd8}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic enc_a_i = 1'b0, enc_b_i = 1'b0, enc_z_i = 1'b0;
  logic swap_i = 1'b0, zero_rst_en_i = 1'b0;
  logic [CNT_W-1:0] max_cnt_i = 8'd9;
  logic [FILT_W-1:0] filt_len_i = 4'd1;
  logic [CNT_W-1:0] count_o;
  logic dir_rev_o, err_o, a_lvl_o, b_lvl_o, z_lvl_o, first_z_o, evt_ovf_o;
  logic [TMR_W-1:0] evt_time_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  qenc_decoder #(.CNT_W(CNT_W), .FILT_W(FILT_W), .TMR_W(TMR_W)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    wait_cyc(3);
    chk(count_o == 0 && err_o == 0 && first_z_o == 0 && evt_ovf_o == 0 &&
        evt_time_o == 0 && a_lvl_o == 0, "R12 reset", count_o, 0);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(count_o == 0, "R12 after release", count_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      {swap_i, enc_a_i, enc_b_i} = VEC[i][10:8];
      wait_cyc(8);
      chk(count_o == VEC[i][7:0], $sformatf("R2 R3 R4 R5 vec%0d", i), count_o, VEC[i][7:0]);
      chk(err_o == 0, "R6 no error on legal step", err_o, 0);
    end
    chk(dir_rev_o == 1, "R5 swapped direction", dir_rev_o, 1);

    // R6: pins 11 -> 00 together
    enc_a_i = 1'b0; enc_b_i = 1'b0;
    wait_cyc(8);
    chk(err_o == 1, "R6 illegal sets err", err_o, 1);
    chk(count_o == 8, "R6 count held", count_o, 8);

    // R7, R9: index with reload disabled
    enc_z_i = 1'b1; wait_cyc(8); enc_z_i = 1'b0; wait_cyc(8);
    chk(count_o == 8, "R7 index ignored", count_o, 8);
    chk(first_z_o == 1, "R9 first index seen", first_z_o, 1);

    // R8: reload after reverse step -> ceiling
    zero_rst_en_i = 1'b1;
    enc_z_i = 1'b1; wait_cyc(8); enc_z_i = 1'b0; wait_cyc(8);
    chk(count_o == 9, "R8 reverse reload to max", count_o, 9);
    // two forward steps with swap: pin b rises, then pin a rises
    enc_b_i = 1'b1; wait_cyc(8);
    enc_a_i = 1'b1; wait_cyc(8);
    chk(count_o == 1, "R4 R5 forward wrap under swap", count_o, 1);
    enc_z_i = 1'b1; wait_cyc(8); enc_z_i = 1'b0; wait_cyc(8);
    chk(count_o == 0, "R8 forward reload to zero", count_o, 0);
    chk(first_z_o == 1, "R9 flag stays set", first_z_o, 1);
    zero_rst_en_i = 1'b0;

    // R1: filter length 3, short pulse rejected
    filt_len_i = 4'd3;
    wait_cyc(2);
    enc_a_i = 1'b0; wait_cyc(2); enc_a_i = 1'b1;
    wait_cyc(12);
    chk(a_lvl_o == 1, "R1 short pulse level", a_lvl_o, 1);
    chk(count_o == 0, "R1 short pulse count", count_o, 0);
    // held change: level moves on edge 6 after the pin
    enc_a_i = 1'b0;
    wait_cyc(5);
    chk(a_lvl_o == 1, "R1 level before latency", a_lvl_o, 1);
    wait_cyc(1);
    chk(a_lvl_o == 0, "R1 level at latency", a_lvl_o, 0);
    chk(count_o == 0, "R2 count lags level", count_o, 0);
    wait_cyc(1);
    chk(count_o == 9, "R3 R4 reverse wrap", count_o, 9);

    // R10, R11: steps 20 cycles apart
    wait_cyc(4);
    enc_b_i = 1'b0; wait_cyc(20);
    enc_a_i = 1'b1; wait_cyc(10);
    chk(evt_time_o == 20, "R10 interval", evt_time_o, 20);
    chk(evt_ovf_o == 0, "R11 cleared by step", evt_ovf_o, 0);
    chk(count_o == 7, "R3 reverse steps", count_o, 7);
    wait_cyc(300);
    chk(evt_ovf_o == 1, "R11 overflow", evt_ovf_o, 1);
    enc_b_i = 1'b1; wait_cyc(10);
    chk(evt_time_o == 8'hFF, "R10 saturated interval", evt_time_o, 255);
    chk(evt_ovf_o == 0, "R11 cleared again", evt_ovf_o, 0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule